// File: doc/BRIEF.md
# D-PHY Transmitter Bring-up Sequencer

This block takes a MIPI D-PHY transmitter from reset to normal operation in a fixed order. Right after reset it holds the PHY in reset and then in shutdown, and it pulses the test-clear line low, high and low, holding each level for a set number of clocks. It then sends test-port commands through a request/done handshake to an external command writer. The first command selects master or slave clocking. Then come up to four lane-rate code/data pairs taken from input ports, and last a command that returns the test port to normal operation.

After the commands it sets the lane-direction field and then this PHY's clock-lane enable bit. It releases shutdown, waits a set gap, and releases reset. It then waits for PLL lock and polls the PHY state machine through status commands until the read-back state matches the expected value. Both waits have a limit. If a limit runs out, the sequencer stops with its error flag high until the next reset. On success it raises its done flag and holds it.

Top module: `dphy_bringup_seq`

## Requirements
- R1: While reset is applied, `phy_rstz` is low, `phy_shutdownz` is high, and `test_clr`, `cmd_req`, `lane_dir`, `clk_lane_en`, `seq_done` and `seq_err` are all zero. On the first clock after reset is released, `phy_shutdownz` goes low while `phy_rstz` stays low.
- R2: `test_clr` stays low for CYC_15NS clocks, then high for CYC_15NS clocks, then low for CYC_15NS clocks. It is only ever high while the PHY is in reset and shutdown.
- R3: `cmd_req` rises one clock after a command step begins. It stays high, with `cmd_code` and `cmd_data` unchanged, until a clock edge at which `cmd_done` is high. It is low on the next clock.
- R4: The first command is code MPHY_CODE. Its data is 0x01 when `master_mode` is 1 and 0x00 when `master_mode` is 0.
- R5: Next come min(`rate_count`, NUM_RATE) lane-rate commands, starting at index 0. Pair i takes its code from `rate_code[8i+7:8i]` and its data from `rate_data[8i+7:8i]`. A count of 0 issues none.
- R6: After the lane-rate commands, a command with code 0x00 and data 0x00 is issued.
- R7: One clock after that command completes, `lane_dir` becomes 0x03F (bits 5:0 set, bits 9:6 clear). One clock later, bit PHY_ID of `clk_lane_en` is set. Both then hold.
- R8: `phy_shutdownz` goes high and stays high for CYC_15NS clocks before `phy_rstz` goes high. `phy_rstz` is never high while `phy_shutdownz` is low.
- R9: Once reset is released, the sequencer moves on at the first clock where `pll_locked` is high. If `pll_locked` stays low for LOCK_TIMEOUT clocks, it enters the error state.
- R10: Each poll is a command with code POLL_CODE and data 0x80. `phy_state` is compared with READY_STATE on the clock of the completing handshake. A match raises `seq_done`. POLL_LIMIT mismatching polls raise `seq_err`.
- R11: `seq_done` and `seq_err` are never high together. Once raised, each one holds, along with all control lines, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = PHY drives its own clock lane |
| rate_count | input | $clog2(NUM_RATE+1) | Number of lane-rate pairs to send |
| rate_code | input | 8*NUM_RATE | Lane-rate command codes, pair i in bits 8i+7:8i |
| rate_data | input | 8*NUM_RATE | Lane-rate command data, pair i in bits 8i+7:8i |
| pll_locked | input | 1 | PLL lock indication |
| phy_state | input | 4 | Read-back PHY state, valid at command completion |
| cmd_done | input | 1 | Command writer has finished the current command |
| phy_rstz | output | 1 | Active-low PHY reset |
| phy_shutdownz | output | 1 | Active-low PHY shutdown |
| test_clr | output | 1 | Test-port clear |
| cmd_req | output | 1 | Command request to the writer |
| cmd_code | output | 8 | Test code of the current command |
| cmd_data | output | 8 | Test data of the current command |
| lane_dir | output | 10 | Lane direction field |
| clk_lane_en | output | NUM_PHY | Clock-lane enables, one per PHY |
| seq_done | output | 1 | Bring-up completed |
| seq_err | output | 1 | A wait timed out |

## Verification
The hardest cases to reach from the ports are the limits of the two waits. These are a lock that arrives in the very last allowed clock, or one clock too late, and a PHY state that matches on the last allowed poll rather than never. The bench builds the lock signal from the number of clocks since it saw `phy_rstz` rise, and the read-back state from the number of poll handshakes it has completed. Each scenario can therefore place the lock and the match exactly on, or one past, the limit. The handshake latency of the command writer also changes between scenarios, so hold and drop timing is checked with different stall lengths.

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq #(
  parameter int          CYC_15NS     = 8,
  parameter int          LOCK_TIMEOUT = 2000,
  parameter int          POLL_LIMIT   = 16,
  parameter int          NUM_RATE     = 4,
  parameter int          NUM_PHY      = 6,
  parameter int          PHY_ID       = 0,
  parameter logic [7:0]  MPHY_CODE    = 8'h25,
  parameter logic [7:0]  POLL_CODE    = 8'h1F,
  parameter logic [3:0]  READY_STATE  = 4'h5,
  localparam int         RCW          = $clog2(NUM_RATE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  master_mode,
  input  logic [RCW-1:0]        rate_count,
  input  logic [8*NUM_RATE-1:0] rate_code,
  input  logic [8*NUM_RATE-1:0] rate_data,
  input  logic                  pll_locked,
  input  logic [3:0]            phy_state,
  input  logic                  cmd_done,
  output logic                  phy_rstz,
  output logic                  phy_shutdownz,
  output logic                  test_clr,
  output logic                  cmd_req,
  output logic [7:0]            cmd_code,
  output logic [7:0]            cmd_data,
  output logic [9:0]            lane_dir,
  output logic [NUM_PHY-1:0]    clk_lane_en,
  output logic                  seq_done,
  output logic                  seq_err
);
  localparam int IDXW = (NUM_RATE > 1) ? $clog2(NUM_RATE) : 1;
  localparam int MAXW = (LOCK_TIMEOUT > POLL_LIMIT) ? LOCK_TIMEOUT : POLL_LIMIT;
  localparam int MAXC = (MAXW > CYC_15NS) ? MAXW : CYC_15NS;
  localparam int CNTW = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_INIT, S_SHUT, S_CLR0, S_CLR1, S_CLR2, S_MPHY, S_RATE, S_NORM,
    S_DIR, S_CLKEN, S_RELSD, S_LOCK, S_POLL, S_DONE, S_ERR
  } st_t;

  st_t            st;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] idx;
  logic [RCW-1:0]  n_pairs;
  logic            gap_end;

  assign n_pairs = (rate_count > RCW'(NUM_RATE)) ? RCW'(NUM_RATE) : rate_count;
  assign gap_end = (cnt == CNTW'(CYC_15NS - 1));

  assign phy_rstz      = (st >= S_LOCK);
  assign phy_shutdownz = (st == S_INIT) || (st >= S_RELSD);
  assign test_clr      = (st == S_CLR1);
  assign lane_dir      = (st >= S_DIR) ? 10'h03F : 10'h000;
  assign clk_lane_en   = (st >= S_CLKEN) ? (NUM_PHY'(1) << PHY_ID) : '0;
  assign seq_done      = (st == S_DONE);
  assign seq_err       = (st == S_ERR);

  always_comb begin
    cmd_code = 8'h00;
    cmd_data = 8'h00;
    case (st)
      S_MPHY: begin cmd_code = MPHY_CODE; cmd_data = {7'b0, master_mode}; end
      S_RATE: begin cmd_code = rate_code[8*idx +: 8]; cmd_data = rate_data[8*idx +: 8]; end
      S_POLL: begin cmd_code = POLL_CODE; cmd_data = 8'h80; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_INIT;
      cnt     <= '0;
      idx     <= '0;
      cmd_req <= 1'b0;
    end else begin
      case (st)
        S_INIT: st <= S_SHUT;
        S_SHUT: st <= S_CLR0;
        S_CLR0: if (gap_end) begin cnt <= '0; st <= S_CLR1; end else cnt <= cnt + 1'b1;
        S_CLR1: if (gap_end) begin cnt <= '0; st <= S_CLR2; end else cnt <= cnt + 1'b1;
        S_CLR2: if (gap_end) begin cnt <= '0; st <= S_MPHY; end else cnt <= cnt + 1'b1;
        S_MPHY: begin
          if (!cmd_req) cmd_req <= 1'b1;
          else if (cmd_done) begin
            cmd_req <= 1'b0;
            st      <= (n_pairs == '0) ? S_NORM : S_RATE;
          end
        end
        S_RATE: begin
          if (!cmd_req) cmd_req <= 1'b1;
          else if (cmd_done) begin
            cmd_req <= 1'b0;
            if (RCW'(idx) + RCW'(1) >= n_pairs) begin
              idx <= '0;
              st  <= S_NORM;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_NORM: begin
          if (!cmd_req) cmd_req <= 1'b1;
          else if (cmd_done) begin
            cmd_req <= 1'b0;
            st      <= S_DIR;
          end
        end
        S_DIR:   st <= S_CLKEN;
        S_CLKEN: st <= S_RELSD;
        S_RELSD: if (gap_end) begin cnt <= '0; st <= S_LOCK; end else cnt <= cnt + 1'b1;
        S_LOCK: begin
          if (pll_locked) begin
            cnt <= '0;
            st  <= S_POLL;
          end else if (cnt == CNTW'(LOCK_TIMEOUT - 1)) begin
            st <= S_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POLL: begin
          if (!cmd_req) cmd_req <= 1'b1;
          else if (cmd_done) begin
            cmd_req <= 1'b0;
            if (phy_state == READY_STATE) st <= S_DONE;
            else if (cnt == CNTW'(POLL_LIMIT - 1)) st <= S_ERR;
            else cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dphy_bringup_seq_chk.sv
module dphy_bringup_seq_chk #(
  parameter int NUM_PHY = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_req,
  input logic               cmd_done,
  input logic [7:0]         cmd_code,
  input logic [7:0]         cmd_data,
  input logic               phy_rstz,
  input logic               phy_shutdownz,
  input logic               test_clr,
  input logic [9:0]         lane_dir,
  input logic [NUM_PHY-1:0] clk_lane_en,
  input logic               seq_done,
  input logic               seq_err
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> cmd_req);
  a_r3_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> ($stable(cmd_code) && $stable(cmd_data)));
  a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_done) |=> !cmd_req);
  a_r2_clear_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr |-> (!phy_rstz && !phy_shutdownz));
  a_r7_clock_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_lane_en) |-> (lane_dir == 10'h03F));
  a_r7_one_clock_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_lane_en));
  a_r8_reset_after_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rstz |-> phy_shutdownz);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (seq_err && !seq_done));
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (seq_done && !seq_err));
endmodule

bind dphy_bringup_seq dphy_bringup_seq_chk #(.NUM_PHY(NUM_PHY)) u_chk (.*);

// File: tb/sim_dphy_bringup_seq.sv
module sim_dphy_bringup_seq;
  localparam int         CYC      = 8;
  localparam int         LOCK_TO  = 40;
  localparam int         POLL_LIM = 5;
  localparam int         NPHY     = 6;
  localparam int         PID      = 2;
  localparam logic [7:0] MCODE    = 8'h25;
  localparam logic [7:0] PCODE    = 8'h1F;
  localparam logic [3:0] READY    = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b0;
  logic [2:0]  rate_count = '0;
  logic [31:0] rate_code = 32'h9C8B7A69;
  logic [31:0] rate_data = 32'h14233241;
  logic        pll_locked;
  logic [3:0]  phy_state;
  logic        cmd_done;
  logic        phy_rstz, phy_shutdownz, test_clr, cmd_req, seq_done, seq_err;
  logic [7:0]  cmd_code, cmd_data;
  logic [9:0]  lane_dir;
  logic [NPHY-1:0] clk_lane_en;

  always #4 clk = ~clk;

  dphy_bringup_seq #(.CYC_15NS(CYC), .LOCK_TIMEOUT(LOCK_TO), .POLL_LIMIT(POLL_LIM),
    .NUM_RATE(4), .NUM_PHY(NPHY), .PHY_ID(PID), .MPHY_CODE(MCODE),
    .POLL_CODE(PCODE), .READY_STATE(READY)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, lock_dly = 0, ready_after = 1;
  bit lock_en = 1'b0;
  int wcnt = 0, lock_ctr = 0, polls_seen = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model: a queue of expected steps
  int          qk[$];
  int          qa[$];
  logic [4:0]  qp[$];
  string       qt[$];
  int          m_cnt = 0, m_polls = 0;
  bit          m_req = 1'b0, m_err = 1'b0;
  string       m_err_tag = "R11";

  task automatic push(int k, int a, logic [4:0] p, string t);
    qk.push_back(k); qa.push_back(a); qp.push_back(p); qt.push_back(t);
  endtask

  task automatic build(bit master, int n);
    qk.delete(); qa.delete(); qp.delete(); qt.delete();
    push(0, 1, 5'b01000, "R1");
    push(0, 1, 5'b00000, "R1");
    push(0, CYC, 5'b00000, "R2");
    push(0, CYC, 5'b00100, "R2");
    push(0, CYC, 5'b00000, "R2");
    push(1, (int'(MCODE) << 8) | int'(master), 5'b00000, "R4");
    for (int i = 0; i < ((n > 4) ? 4 : n); i++)
      push(1, (int'(rate_code[8*i +: 8]) << 8) | int'(rate_data[8*i +: 8]), 5'b00000, "R5");
    push(1, 0, 5'b00000, "R6");
    push(0, 1, 5'b00010, "R7");
    push(0, 1, 5'b00011, "R7");
    push(0, CYC, 5'b01011, "R8");
    push(2, 0, 5'b11011, "R9");
    push(3, 0, 5'b11011, "R10");
    push(4, 0, 5'b11011, "R11");
  endtask

  task automatic pop();
    qk.delete(0); qa.delete(0); qp.delete(0); qt.delete(0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_polls = 0; m_req = 1'b0; m_err = 1'b0;
    end else if (!m_err && qk.size() > 0) begin
      case (qk[0])
        0: if (m_cnt + 1 == qa[0]) begin m_cnt = 0; pop(); end else m_cnt++;
        1: if (!m_req) m_req = 1'b1;
           else if (cmd_done) begin m_req = 1'b0; pop(); end
        2: if (pll_locked) begin m_cnt = 0; pop(); end
           else if (m_cnt == LOCK_TO - 1) begin m_err = 1'b1; m_err_tag = "R9"; end
           else m_cnt++;
        3: if (!m_req) m_req = 1'b1;
           else if (cmd_done) begin
             m_req = 1'b0;
             if (phy_state == READY) pop();
             else if (m_polls == POLL_LIM - 1) begin m_err = 1'b1; m_err_tag = "R10"; end
             else m_polls++;
           end
        default: ;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && qk.size() > 0) begin
      logic [4:0]  p;
      logic [15:0] ecd;
      logic [37:0] ev, av;
      string       tg;
      p   = m_err ? 5'b11011 : qp[0];
      tg  = m_err ? m_err_tag : qt[0];
      ecd = 16'h0;
      if (m_req) ecd = (qk[0] == 3) ? {PCODE, 8'h80} : qa[0][15:0];
      ev = {p[4], p[3], p[2], p[1] ? 10'h03F : 10'h000,
            p[0] ? NPHY'(1) << PID : NPHY'(0),
            !m_err && qk[0] == 4, m_err, ecd};
      av = {phy_rstz, phy_shutdownz, test_clr, lane_dir, clk_lane_en,
            seq_done, seq_err, cmd_req ? {cmd_code, cmd_data} : 16'h0};
      check("R3", cmd_req, m_req);
      check(tg, av, ev);
    end
  end

  // command writer, PLL and PHY-state stimulus
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_done = 1'b0; wcnt = 0; lock_ctr = 0; pll_locked = 1'b0;
      polls_seen = 0; phy_state = 4'h2;
    end else begin
      if (cmd_done) cmd_done = 1'b0;
      else if (cmd_req) begin
        if (wcnt >= lat) begin
          cmd_done = 1'b1;
          wcnt = 0;
          if (cmd_code == PCODE && cmd_data == 8'h80) begin
            polls_seen++;
            phy_state = (polls_seen >= ready_after) ? READY : 4'h2;
          end
        end else wcnt++;
      end
      lock_ctr   = phy_rstz ? lock_ctr + 1 : 0;
      pll_locked = lock_en && (lock_ctr > lock_dly);
    end
  end

  task automatic run(bit master, int n, int l, bit len, int ldly, int rdy, bit exp_ok);
    rst_n = 1'b0;
    master_mode = master; rate_count = 3'(n);
    lat = l; lock_en = len; lock_dly = ldly; ready_after = rdy;
    @(negedge clk);
    build(master, n);
    check("R1", {phy_rstz, phy_shutdownz, test_clr, lane_dir, clk_lane_en,
                 cmd_req, seq_done, seq_err}, {1'b0, 1'b1, 20'h0});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_err || qk[0] == 4) break;
    end
    repeat (20) @(negedge clk);
    check("R11", {seq_done, seq_err}, exp_ok ? 2'b10 : 2'b01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(1'b1, 2, 1, 1'b1, 5,  3,   1'b1);  // master, two pairs
    run(1'b0, 0, 0, 1'b1, 0,  1,   1'b1);  // slave, no pairs, first poll ready
    run(1'b1, 6, 3, 1'b1, 39, 5,   1'b1);  // capped pairs, lock and match at limits
    run(1'b0, 4, 2, 1'b0, 0,  1,   1'b0);  // R9 lock never comes
    run(1'b1, 1, 0, 1'b1, 2,  100, 1'b0);  // R10 state never matches
    run(1'b0, 3, 1, 1'b1, 40, 1,   1'b0);  // R9 lock one clock late
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule